// File: doc/BRIEF.md
# Power-Fail-Gated Static Memory Front End

This block sits between a host bus and a byte-wide static memory array. The host drives the classic active-low strobes (chip select, output enable, write enable), an address and write data. The block samples them on the system clock. From the sampled strobes it decides whether the host is reading, writing or not addressing the memory at all. It drives the enable for the three-state data-out buffer, and it issues clean, single-cycle write strobes and read enables to the array.

A supply-fail input from an external voltage monitor overrides all of this. While it is asserted, the memory is deselected: the data bus stays undriven, reads stop and no write reaches the array. Any write window that is open at that moment is thrown away. When the supply comes back, a recovery counter keeps the host locked out for a fixed number of clock cycles. The same lockout follows reset. Host strobes are recognised again only once the counter has expired. The terminal count is a parameter: a real system sets it to cover tens of milliseconds, and a simulation can use a short value.

A write window is the run of samples in which chip select and write enable are both low. It opens when the later of the two falls and closes when the earlier of the two rises. The window is committed to the array only if three things hold: it opened while the host was allowed access, it lasted at least one sample, and the supply-fail input stayed low for all of it.

Top module: `sram_pf_front`

## Requirements
- R1: While reset is applied and in the first cycle after it, `host_ready_o` is 0, `mode_o` is 2'b11 (locked), and `bus_oe_o`, `mem_rd_o` and `mem_we_o` are 0.
- R2: `host_ready_o` rises exactly RECOV_CYCLES clock edges after reset is released, or after the last edge at which `pwr_fail_i` was sampled high, provided `pwr_fail_i` stays low in between. Any high sample restarts the count.
- R3: With access allowed, a sample with `ce_n_i`=0 and `we_n_i`=1 gives, in the next cycle: `mode_o`=2'b01 (read), `mem_rd_o`=1 and `mem_addr_o` equal to the sampled address. `bus_oe_o`=1 only if `oe_n_i` was also 0.
- R4: A sample with `we_n_i`=0 makes `bus_oe_o` 0 in the next cycle. With chip select low and access allowed, `mode_o` becomes 2'b10 (write).
- R5: A sample with `ce_n_i`=1 makes `bus_oe_o` and `mem_rd_o` 0 in the next cycle, whatever `oe_n_i` and `we_n_i` are. With access allowed, `mode_o` becomes 2'b00 (deselect).
- R6: In the cycle after the first sample that closes a qualified write window, `mem_we_o` is 1 for exactly one cycle. In that cycle `mem_addr_o` holds the address sampled when the window opened, and `mem_wdata_o` holds the data sampled at the last sample inside the window.
- R7: A window of a single sample is committed. A window closed by `ce_n_i` rising is committed in the same way as one closed by `we_n_i` rising.
- R8: A sample with `pwr_fail_i`=1 gives, in the next cycle: `bus_oe_o`, `mem_rd_o`, `mem_we_o` and `host_ready_o` all 0, and `mode_o`=2'b11. A write window open at that sample never produces a strobe.
- R9: A write window that opens while `host_ready_o` is 0 never produces a strobe, even if it closes after access is allowed again.
- R10: In the cycle a write strobe is issued, `mem_rd_o` is 0 and `mem_addr_o` shows the write address. The pending read address appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Supply out of tolerance, active high |
| ce_n_i | input | 1 | Host chip select, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | DATA_W | Host write data |
| bus_oe_o | output | 1 | Enable for the data-out three-state buffer |
| mem_rd_o | output | 1 | Array read enable |
| mem_we_o | output | 1 | Array write strobe, one cycle |
| mem_addr_o | output | ADDR_W | Array address |
| mem_wdata_o | output | DATA_W | Array write data |
| mode_o | output | 2 | 00 deselect, 01 read, 10 write, 11 locked |
| host_ready_o | output | 1 | Access is allowed (recovery has expired) |

## Verification
The checker tests the following rules on every cycle:
- A supply-fail sample shuts every output off in the next cycle.
- A high chip select, or a low write enable, removes the bus drive.
- Bus drive only follows a sample with chip select and output enable both low.
- A write strobe is always a single pulse. It follows a sample in which the window was closed, and it never coincides with a read enable.
- Access never becomes ready straight after a supply-fail sample.

Some behaviours only the bench's directed scenarios can show:
- the exact length of the recovery lockout;
- that the committed address is the one from the window's opening and the data is from its last sample;
- that windows aborted by a supply failure, or opened during the lockout, never reach the array.

// File: rtl/sram_pf_pkg.sv
package sram_pf_pkg;

    // Host-visible access mode; the encoding is part of the block's contract.
    typedef enum logic [1:0] {
        MODE_DESEL  = 2'b00,
        MODE_READ   = 2'b01,
        MODE_WRITE  = 2'b10,
        MODE_LOCKED = 2'b11
    } bus_mode_e;

    // Progress of one host write window.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'b00,
        WIN_OPEN  = 2'b01,
        WIN_ABORT = 2'b10
    } win_state_e;

endpackage

// File: rtl/sram_pf_lock.sv
// Recovery lockout: reset or any supply-fail sample clears the counter;
// access is allowed after RECOV_CYCLES consecutive quiet samples.
module sram_pf_lock #(
    parameter int unsigned RECOV_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_fail_i,
    output logic ready_o
);
    localparam int unsigned CNT_W = (RECOV_CYCLES > 1) ? $clog2(RECOV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOV_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (pwr_fail_i) begin
            lock_d.cnt   = '0;
            lock_d.ready = 1'b0;
        end else if (!lock_q.ready) begin
            if (lock_q.cnt == LAST) begin
                lock_d.ready = 1'b1;
            end else begin
                lock_d.cnt = lock_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign ready_o = lock_q.ready;

endmodule

// File: rtl/sram_wr_qual.sv
// Write-window qualifier: tracks one host write window and emits a single
// registered strobe when a window that was allowed from start to end closes.
module sram_wr_qual
    import sram_pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pwr_fail_i,
    input  logic              ready_i,
    output logic              strobe_next_o,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        win_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              strobe;
    } win_t;

    win_t win_d, win_q;
    logic active;
    logic blocked;

    assign active  = sel_i && wr_i;
    assign blocked = pwr_fail_i || !ready_i;

    always_comb begin
        win_d        = win_q;
        win_d.strobe = 1'b0;
        unique case (win_q.st)
            WIN_IDLE: begin
                if (active) begin
                    if (blocked) begin
                        win_d.st = WIN_ABORT;
                    end else begin
                        win_d.st   = WIN_OPEN;
                        win_d.addr = addr_i;
                        win_d.data = data_i;
                    end
                end
            end
            WIN_OPEN: begin
                if (blocked) begin
                    win_d.st = WIN_ABORT;
                end else if (active) begin
                    win_d.data = data_i;
                end else begin
                    win_d.st     = WIN_IDLE;
                    win_d.strobe = 1'b1;
                end
            end
            WIN_ABORT: begin
                if (!active) begin
                    win_d.st = WIN_IDLE;
                end
            end
            default: begin
                win_d.st = WIN_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q <= '{st: WIN_IDLE, addr: '0, data: '0, strobe: 1'b0};
        end else begin
            win_q <= win_d;
        end
    end

    assign strobe_next_o = win_d.strobe;
    assign strobe_o      = win_q.strobe;
    assign waddr_o       = win_q.addr;
    assign wdata_o       = win_q.data;

endmodule

// File: rtl/sram_mode_dec.sv
// Mode decoder: classifies each strobe sample and registers the bus-drive
// and read-enable controls that follow from it.
module sram_mode_dec
    import sram_pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pwr_fail_i,
    input  logic              ready_i,
    input  logic              wr_strobe_next_i,
    output bus_mode_e         mode_o,
    output logic              drive_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] raddr_o
);
    typedef struct packed {
        bus_mode_e         mode;
        logic              drive;
        logic              rd;
        logic [ADDR_W-1:0] raddr;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (pwr_fail_i || !ready_i) begin
            dec_d.mode = MODE_LOCKED;
        end else if (ce_n_i) begin
            dec_d.mode = MODE_DESEL;
        end else if (!we_n_i) begin
            dec_d.mode = MODE_WRITE;
        end else begin
            dec_d.mode = MODE_READ;
        end
        dec_d.drive = (dec_d.mode == MODE_READ) && !oe_n_i;
        dec_d.rd    = (dec_d.mode == MODE_READ) && !wr_strobe_next_i;
        dec_d.raddr = addr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= '{mode: MODE_LOCKED, drive: 1'b0, rd: 1'b0, raddr: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign mode_o  = dec_q.mode;
    assign drive_o = dec_q.drive;
    assign rd_o    = dec_q.rd;
    assign raddr_o = dec_q.raddr;

endmodule

// File: rtl/sram_pf_front.sv
// Top: power-fail-gated front end for a byte-wide static memory.
module sram_pf_front
    import sram_pf_pkg::*;
#(
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned RECOV_CYCLES = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_fail_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              bus_oe_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [1:0]        mode_o,
    output logic              host_ready_o
);
    logic              ready;
    logic              strobe_next;
    logic              strobe;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] wdata;
    bus_mode_e         mode;

    sram_pf_lock #(
        .RECOV_CYCLES(RECOV_CYCLES)
    ) i_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwr_fail_i (pwr_fail_i),
        .ready_o    (ready)
    );

    sram_wr_qual #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_wr (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sel_i         (!ce_n_i),
        .wr_i          (!we_n_i),
        .addr_i        (addr_i),
        .data_i        (wdata_i),
        .pwr_fail_i    (pwr_fail_i),
        .ready_i       (ready),
        .strobe_next_o (strobe_next),
        .strobe_o      (strobe),
        .waddr_o       (waddr),
        .wdata_o       (wdata)
    );

    sram_mode_dec #(
        .ADDR_W(ADDR_W)
    ) i_dec (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .ce_n_i           (ce_n_i),
        .oe_n_i           (oe_n_i),
        .we_n_i           (we_n_i),
        .addr_i           (addr_i),
        .pwr_fail_i       (pwr_fail_i),
        .ready_i          (ready),
        .wr_strobe_next_i (strobe_next),
        .mode_o           (mode),
        .drive_o          (bus_oe_o),
        .rd_o             (mem_rd_o),
        .raddr_o          (raddr)
    );

    assign mem_we_o     = strobe;
    assign mem_addr_o   = strobe ? waddr : raddr;
    assign mem_wdata_o  = wdata;
    assign mode_o       = mode;
    assign host_ready_o = ready;

endmodule

// File: rtl/sram_pf_front_chk.sv
module sram_pf_front_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pwr_fail_i,
    input logic       ce_n_i,
    input logic       oe_n_i,
    input logic       we_n_i,
    input logic       bus_oe_o,
    input logic       mem_rd_o,
    input logic       mem_we_o,
    input logic [1:0] mode_o,
    input logic       host_ready_o
);
    // R8
    pf_gates_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_fail_i |=> (!bus_oe_o && !mem_rd_o && !mem_we_o && !host_ready_o && mode_o == 2'b11));

    // R5
    deselect_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_n_i |=> (!bus_oe_o && !mem_rd_o));

    // R4
    we_low_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_i |=> !bus_oe_o);

    // R3
    drive_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> ($past(!oe_n_i) && $past(!ce_n_i)));

    // R6
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> !mem_we_o);

    // R6
    strobe_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> ($past(ce_n_i || we_n_i) && !$past(pwr_fail_i)));

    // R10
    strobe_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> !mem_rd_o);

    // R2
    ready_after_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_ready_o) |-> !$past(pwr_fail_i));

endmodule

bind sram_pf_front sram_pf_front_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_fail_i   (pwr_fail_i),
    .ce_n_i       (ce_n_i),
    .oe_n_i       (oe_n_i),
    .we_n_i       (we_n_i),
    .bus_oe_o     (bus_oe_o),
    .mem_rd_o     (mem_rd_o),
    .mem_we_o     (mem_we_o),
    .mode_o       (mode_o),
    .host_ready_o (host_ready_o)
);

// File: tb/test_sram_pf_front.sv
`timescale 1ns/1ps
module test_sram_pf_front;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int RC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          bus_oe, mem_rd, mem_we, ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0]    mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_pf_front #(.ADDR_W(AW), .DATA_W(DW), .RECOV_CYCLES(RC)) i_sram_pf_front (
        .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pf), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .we_n_i(we_n), .addr_i(addr), .wdata_i(wdata), .bus_oe_o(bus_oe),
        .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mode_o(mode), .host_ready_o(ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; pf = 1'b0;
    endtask

    // R1 reset state, R2 lockout after reset
    task automatic t_reset_recovery();
        bus_idle();
        rst_n = 1'b0;
        tick(3);
        chk("R1 ready in reset", ready, 0);
        chk("R1 mode in reset", mode, 2'b11);
        chk("R1 outputs in reset", {bus_oe, mem_rd, mem_we}, 0);
        ce_n = 1'b0; oe_n = 1'b0;
        rst_n = 1'b1;
        tick(1);
        chk("R1 mode first cycle", mode, 2'b11);
        chk("R1 no drive first cycle", bus_oe, 0);
        tick(RC - 2);
        chk("R2 still locked at RC-1", ready, 0);
        chk("R2 no drive while locked", bus_oe, 0);
        tick(1);
        chk("R2 ready at RC", ready, 1);
        tick(1);
        chk("R3 read after recovery", mode, 2'b01);
        chk("R3 drive after recovery", bus_oe, 1);
        bus_idle();
        tick(1);
    endtask

    // R3 read, R4 write enable kills drive, R5 deselect
    task automatic t_read_modes();
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 15'h7FFF;
        tick(1);
        chk("R3 mode read", mode, 2'b01);
        chk("R3 bus drive", bus_oe, 1);
        chk("R3 read enable", mem_rd, 1);
        chk("R3 read address", mem_addr, 15'h7FFF);
        oe_n = 1'b1; addr = 15'h0123;
        tick(1);
        chk("R3 oe high no drive", bus_oe, 0);
        chk("R3 oe high still reads", mem_rd, 1);
        chk("R3 address follows", mem_addr, 15'h0123);
        oe_n = 1'b0; we_n = 1'b0;
        tick(1);
        chk("R4 we low no drive", bus_oe, 0);
        chk("R4 mode write", mode, 2'b10);
        ce_n = 1'b1; we_n = 1'b1;
        tick(1);
        chk("R5 deselect mode", mode, 2'b00);
        chk("R5 deselect no drive", bus_oe, 0);
        chk("R5 deselect no read", mem_rd, 0);
        oe_n = 1'b0; we_n = 1'b0;
        tick(1);
        chk("R5 ce high overrides strobes", {bus_oe, mem_rd, mem_we}, 0);
        chk("R5 ce high mode", mode, 2'b00);
        bus_idle();
        tick(2);
    endtask

    // R6 committed address and data, R7 single sample closed by ce
    task automatic t_write();
        ce_n = 1'b0; we_n = 1'b0; addr = 15'h1A2B; wdata = 8'h11;
        tick(1);
        chk("R6 no strobe while open", mem_we, 0);
        addr = 15'h0555; wdata = 8'h22;
        tick(1);
        wdata = 8'h33; we_n = 1'b1; ce_n = 1'b1;
        tick(1);
        chk("R6 strobe", mem_we, 1);
        chk("R6 opening address", mem_addr, 15'h1A2B);
        chk("R6 last data", mem_wdata, 8'h22);
        tick(1);
        chk("R6 single pulse", mem_we, 0);
        ce_n = 1'b0; we_n = 1'b0; addr = 15'h4000; wdata = 8'hA5;
        tick(1);
        ce_n = 1'b1;
        tick(1);
        chk("R7 single sample ce close strobe", mem_we, 1);
        chk("R7 address", mem_addr, 15'h4000);
        chk("R7 data", mem_wdata, 8'hA5);
        bus_idle();
        tick(2);
    endtask

    // R10 read enable held off in strobe cycle
    task automatic t_priority();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 15'h0042; wdata = 8'h5C;
        tick(1);
        we_n = 1'b1; addr = 15'h0077;
        tick(1);
        chk("R10 strobe", mem_we, 1);
        chk("R10 no read in strobe", mem_rd, 0);
        chk("R10 write address shown", mem_addr, 15'h0042);
        tick(1);
        chk("R10 read follows", mem_rd, 1);
        chk("R10 read address follows", mem_addr, 15'h0077);
        bus_idle();
        tick(2);
    endtask

    // R8 power fail aborts window and gates outputs, R2 restart
    task automatic t_pf_abort();
        int seen;
        seen = 0;
        ce_n = 1'b0; we_n = 1'b0; addr = 15'h0100; wdata = 8'hEE;
        tick(1);
        pf = 1'b1;
        tick(1);
        chk("R8 ready drops", ready, 0);
        chk("R8 locked mode", mode, 2'b11);
        chk("R8 no strobe", mem_we, 0);
        pf = 1'b0; we_n = 1'b1;
        for (int i = 0; i < RC - 1; i++) begin
            tick(1);
            if (mem_we) seen++;
        end
        chk("R8 aborted window never written", seen, 0);
        chk("R2 locked at RC-1 after fail", ready, 0);
        tick(1);
        chk("R2 ready at RC after fail", ready, 1);
        oe_n = 1'b0;
        tick(1);
        chk("R3 drive before fail", bus_oe, 1);
        pf = 1'b1;
        tick(1);
        chk("R8 read drive cut", {bus_oe, mem_rd}, 0);
        chk("R8 locked while reading", mode, 2'b11);
        pf = 1'b0;
        tick(3);
        pf = 1'b1;
        tick(1);
        pf = 1'b0;
        tick(RC - 1);
        chk("R2 restart by second fail", ready, 0);
        tick(1);
        chk("R2 ready after restart", ready, 1);
        bus_idle();
        tick(2);
    endtask

    // R9 window opened during lockout
    task automatic t_locked_window();
        int seen;
        seen = 0;
        pf = 1'b1;
        tick(1);
        pf = 1'b0; ce_n = 1'b0; we_n = 1'b0; addr = 15'h0200; wdata = 8'h99;
        tick(RC + 2);
        chk("R9 ready while window held", ready, 1);
        we_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            if (mem_we) seen++;
        end
        chk("R9 locked window not written", seen, 0);
        bus_idle();
        tick(1);
    endtask

    initial begin
        t_reset_recovery();
        t_read_modes();
        t_write();
        t_priority();
        t_pf_abort();
        t_locked_window();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule